// File: doc/BRIEF.md
# Perturb-and-Observe Maximum Power Point Tracker

This block holds a photovoltaic source close to the point where it delivers the most power. It does this by nudging the duty cycle of a switching converter. At each control update it takes a voltage code and a current code, multiplies them into a power value, and compares both power and voltage with the values stored at the previous update. The two signs select the direction of the next voltage move. Because a higher duty lowers the load the source sees, and so lowers the source voltage, a move up in voltage becomes a duty decrement. A move down in voltage becomes a duty increment. The step is programmable: a large step tracks faster but ripples more around the optimum.

Duty is held between programmable lower and upper limits. When the duty already sits on a limit and the rule asks to push further into it, the step goes the other way instead. Enabling the block loads a programmable starting duty. The first update then always moves the voltage upward. A built-in counter PWM with a 66-cycle period drives the converter switch from the current duty. The duty comes from a shadow copy that is refreshed only at period boundaries.

Top module: `pno_mppt`

## Requirements
- R1: While `enable` is low, `dutyNow` is 0 and `pwmOut` is low; dropping `enable` clears the duty at the next clock edge.
- R2: On the first clock edge at which `enable` is high after being low, `dutyNow` takes `dutyInit` limited to the range [`dutyMin`, `dutyMax`].
- R3: The first `sampleValid` after enabling moves the voltage up, that is, `dutyNow` decreases by `stepSize`, updated at that same clock edge.
- R4: When power rose and voltage rose relative to the previous sample, `dutyNow` decreases by `stepSize`.
- R5: When power rose and voltage fell or stayed equal, `dutyNow` increases by `stepSize`.
- R6: When power fell or stayed equal and voltage rose, `dutyNow` increases by `stepSize`.
- R7: When power fell or stayed equal and voltage fell or stayed equal, `dutyNow` decreases by `stepSize`; equal power and equal voltage therefore count as falls.
- R8: A step that would leave [`dutyMin`, `dutyMax`] stops at the crossed limit.
- R9: If `dutyNow` equals `dutyMin` and the rule asks for a decrease, the duty increases by `stepSize` instead; if it equals `dutyMax` and the rule asks for an increase, the duty decreases by `stepSize` instead.
- R10: Clock edges without `sampleValid` leave `dutyNow` unchanged.
- R11: `pwmOut` repeats every 66 clock cycles and is high for min(duty, 66) cycles of each period. A duty change is applied from the following period boundary.
- R12: Power is the full 20-bit unsigned product of the two 10-bit codes; no bits are dropped before the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the tracker; low clears it |
| sampleValid | input | 1 | One-cycle strobe marking a fresh voltage/current pair |
| voltCode | input | 10 | Averaged source voltage code |
| currCode | input | 10 | Averaged source current code |
| stepSize | input | 7 | Duty perturbation step in PWM counts |
| dutyMin | input | 7 | Lower duty limit |
| dutyMax | input | 7 | Upper duty limit |
| dutyInit | input | 7 | Duty loaded on enable |
| pwmOut | output | 1 | Converter switch drive |
| dutyNow | output | 7 | Current duty in PWM counts |

## Verification
The hardest case to reach is the forced reversal at a limit. The duty must first land exactly on `dutyMin` or `dutyMax`, and only then may a sample pattern arrive that asks to push further. The bench reaches each limit with a clamping step from a starting duty chosen just inside it. It then feeds a power/voltage pair whose signs call for the blocked direction. The product width is checked with full-scale codes. Their true product falls while the low ten bits of the product rise, so a truncated product would choose the opposite step.

// File: rtl/pno_pkg.sv
package pno_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_TRACK = 2'd2
  } trackState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearDuty;
    logic loadInit;
    logic incDuty;
    logic decDuty;
    logic capture;
  } dpCmd_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic powerRose;
    logic voltRose;
    logic atMin;
    logic atMax;
  } dpFlags_t;

endpackage

// File: rtl/pno_datapath.sv
module pno_datapath
  import pno_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [CODE_W-1:0] voltCode,
  input  logic [CODE_W-1:0] currCode,
  input  logic [DUTY_W-1:0] stepSize,
  input  logic [DUTY_W-1:0] dutyMin,
  input  logic [DUTY_W-1:0] dutyMax,
  input  logic [DUTY_W-1:0] dutyInit,
  output dpFlags_t          flags,
  output logic [DUTY_W-1:0] duty
);

  localparam int PWR_W = 2 * CODE_W;

  logic [PWR_W-1:0]  powerNow;
  logic [PWR_W-1:0]  prevPower;
  logic [CODE_W-1:0] prevVolt;
  logic [DUTY_W:0]   upSum;
  logic [DUTY_W:0]   lowBound;
  logic [DUTY_W-1:0] upVal;
  logic [DUTY_W-1:0] downVal;
  logic [DUTY_W-1:0] initVal;

  assign powerNow = PWR_W'(voltCode) * PWR_W'(currCode);

  assign upSum    = {1'b0, duty} + {1'b0, stepSize};
  assign lowBound = {1'b0, dutyMin} + {1'b0, stepSize};

  always_comb begin
    if (upSum > {1'b0, dutyMax}) upVal = dutyMax;
    else                         upVal = upSum[DUTY_W-1:0];

    if ({1'b0, duty} < lowBound) downVal = dutyMin;
    else                         downVal = duty - stepSize;

    if (dutyInit < dutyMin)      initVal = dutyMin;
    else if (dutyInit > dutyMax) initVal = dutyMax;
    else                         initVal = dutyInit;
  end

  always_comb begin
    flags.powerRose = powerNow > prevPower;
    flags.voltRose  = voltCode > prevVolt;
    flags.atMin     = duty <= dutyMin;
    flags.atMax     = duty >= dutyMax;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      duty <= '0;
    end else if (cmd.clearDuty) begin
      duty <= '0;
    end else if (cmd.loadInit) begin
      duty <= initVal;
    end else if (cmd.incDuty) begin
      duty <= upVal;
    end else if (cmd.decDuty) begin
      duty <= downVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPower <= '0;
      prevVolt  <= '0;
    end else if (cmd.capture) begin
      prevPower <= powerNow;
      prevVolt  <= voltCode;
    end
  end

endmodule

// File: rtl/pno_control.sv
module pno_control
  import pno_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     sampleValid,
  input  dpFlags_t flags,
  output dpCmd_t   cmd
);

  trackState_t state, stateNext;
  logic voltUp;
  logic wantDec;
  logic doStep;

  // voltage direction: repeat a move that paid off, reverse one that did not
  always_comb begin
    if (state == ST_FIRST)   voltUp = 1'b1;
    else if (flags.powerRose) voltUp = flags.voltRose;
    else                      voltUp = !flags.voltRose;
  end

  // higher duty lowers source voltage; limits reverse a blocked move
  always_comb begin
    wantDec = voltUp;
    if (voltUp && flags.atMin)       wantDec = 1'b0;
    else if (!voltUp && flags.atMax) wantDec = 1'b1;
  end

  assign doStep = sampleValid && (state != ST_IDLE);

  always_comb begin
    cmd       = '0;
    stateNext = state;
    if (!enable) begin
      cmd.clearDuty = 1'b1;
      stateNext     = ST_IDLE;
    end else if (state == ST_IDLE) begin
      cmd.loadInit = 1'b1;
      stateNext    = ST_FIRST;
    end else if (doStep) begin
      cmd.capture = 1'b1;
      cmd.decDuty = wantDec;
      cmd.incDuty = !wantDec;
      stateNext   = ST_TRACK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/pno_pwm.sv
module pno_pwm #(
  parameter int DUTY_W = 7,
  parameter int PERIOD = 66
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwmOut
);

  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DUTY_W-1:0] shadow;
  logic              wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      shadow <= '0;
      pwmOut <= 1'b0;
    end else if (!enable) begin
      cnt    <= '0;
      shadow <= '0;
      pwmOut <= 1'b0;
    end else begin
      cnt    <= wrap ? '0 : cnt + 1'b1;
      if (wrap) shadow <= duty;
      pwmOut <= 32'(cnt) < 32'(shadow);
    end
  end

endmodule

// File: rtl/pno_mppt.sv
module pno_mppt #(
  parameter int CODE_W = 10,
  parameter int DUTY_W = 7,
  parameter int PERIOD = 66
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] voltCode,
  input  logic [CODE_W-1:0] currCode,
  input  logic [DUTY_W-1:0] stepSize,
  input  logic [DUTY_W-1:0] dutyMin,
  input  logic [DUTY_W-1:0] dutyMax,
  input  logic [DUTY_W-1:0] dutyInit,
  output logic              pwmOut,
  output logic [DUTY_W-1:0] dutyNow
);

  pno_pkg::dpCmd_t   cmd;
  pno_pkg::dpFlags_t flags;

  pno_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .sampleValid (sampleValid),
    .flags       (flags),
    .cmd         (cmd)
  );

  pno_datapath #(.CODE_W(CODE_W), .DUTY_W(DUTY_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .voltCode (voltCode),
    .currCode (currCode),
    .stepSize (stepSize),
    .dutyMin  (dutyMin),
    .dutyMax  (dutyMax),
    .dutyInit (dutyInit),
    .flags    (flags),
    .duty     (dutyNow)
  );

  pno_pwm #(.DUTY_W(DUTY_W), .PERIOD(PERIOD)) i_pwm (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .duty   (dutyNow),
    .pwmOut (pwmOut)
  );

endmodule

// File: rtl/pno_mppt_chk.sv
module pno_mppt_chk #(
  parameter int DUTY_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              sampleValid,
  input logic [DUTY_W-1:0] stepSize,
  input logic [DUTY_W-1:0] dutyMin,
  input logic [DUTY_W-1:0] dutyMax,
  input logic              pwmOut,
  input logic [DUTY_W-1:0] dutyNow
);

  AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (dutyNow == '0)) else $error("duty not cleared"); // R1

  AST_DISABLED_PWM_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut) else $error("pwm active while disabled"); // R1

  AST_HOLD_WITHOUT_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !sampleValid) |=> $stable(dutyNow))
    else $error("duty moved without sample"); // R10

  AST_DUTY_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $past(enable, 2) && dutyMin <= dutyMax
     && $stable(dutyMin) && $stable(dutyMax)
     && $past(dutyMin) == $past(dutyMin, 2) && $past(dutyMax) == $past(dutyMax, 2))
    |-> (dutyNow >= dutyMin && dutyNow <= dutyMax))
    else $error("duty outside limits"); // R8

  AST_STEP_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && sampleValid && stepSize != '0 && dutyMin < dutyMax
     && dutyNow >= dutyMin && dutyNow <= dutyMax)
    |=> (dutyNow != $past(dutyNow)))
    else $error("step left duty unchanged"); // R9

endmodule

bind pno_mppt pno_mppt_chk #(.DUTY_W(DUTY_W)) i_pno_mppt_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .sampleValid (sampleValid),
  .stepSize    (stepSize),
  .dutyMin     (dutyMin),
  .dutyMax     (dutyMax),
  .pwmOut      (pwmOut),
  .dutyNow     (dutyNow)
);

// File: tb/test_pno_mppt.sv
`timescale 1ns/1ps
module test_pno_mppt;

  localparam int CODE_W = 10;
  localparam int DUTY_W = 7;
  localparam int PERIOD = 66;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              sampleValid = 1'b0;
  logic [CODE_W-1:0] voltCode = '0;
  logic [CODE_W-1:0] currCode = '0;
  logic [DUTY_W-1:0] stepSize = '0;
  logic [DUTY_W-1:0] dutyMin = '0;
  logic [DUTY_W-1:0] dutyMax = '0;
  logic [DUTY_W-1:0] dutyInit = '0;
  logic              pwmOut;
  logic [DUTY_W-1:0] dutyNow;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pno_mppt #(.CODE_W(CODE_W), .DUTY_W(DUTY_W), .PERIOD(PERIOD)) i_pno_mppt (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleValid(sampleValid),
    .voltCode(voltCode), .currCode(currCode), .stepSize(stepSize),
    .dutyMin(dutyMin), .dutyMax(dutyMax), .dutyInit(dutyInit),
    .pwmOut(pwmOut), .dutyNow(dutyNow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input int st, input int mn, input int mx, input int ini);
    stepSize = DUTY_W'(st);
    dutyMin  = DUTY_W'(mn);
    dutyMax  = DUTY_W'(mx);
    dutyInit = DUTY_W'(ini);
  endtask

  // raise enable at a negedge; duty loads at the next posedge
  task automatic startTracker(input string req, input int expInit);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(req, dutyNow, expInit);
  endtask

  task automatic stopTracker();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R1 duty cleared", dutyNow, 0);
    @(negedge clk);
    check("R1 pwm low", pwmOut, 0);
  endtask

  task automatic feed(input string req, input int v, input int i, input int expDuty);
    @(negedge clk);
    voltCode    = CODE_W'(v);
    currCode    = CODE_W'(i);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check(req, dutyNow, expDuty);
  endtask

  task automatic countHigh(input string req, input int expHigh);
    int highs = 0;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
    check(req, highs, expHigh);
  endtask

  task automatic tReset();
    check("R1 reset duty", dutyNow, 0);
    check("R1 reset pwm", pwmOut, 0);
  endtask

  task automatic tDecisionTable();
    configure(4, 10, 60, 30);
    startTracker("R2 init load", 30);
    feed("R3 first step raises voltage", 500, 400, 26);
    feed("R4 P up V up", 520, 400, 22);
    feed("R5 P up V down", 510, 420, 26);
    feed("R6 P down V up", 530, 380, 30);
    feed("R7 P down V down", 520, 380, 26);
    feed("R7 equal P equal V", 520, 380, 22);
    for (int k = 0; k < 2 * PERIOD + 4; k++) @(negedge clk);
    check("R10 hold without sample", dutyNow, 22);
    countHigh("R11 pwm high count", 22);
    feed("R4 full-scale rise", 1023, 1023, 18);
    feed("R12 full product fall", 1023, 1022, 14);
    stopTracker();
  endtask

  task automatic tClampMin();
    configure(4, 10, 60, 12);
    startTracker("R2 init inside range", 12);
    feed("R8 clamp at min", 100, 100, 10);
    feed("R9 forced up at min", 110, 100, 14);
    stopTracker();
  endtask

  task automatic tClampMax();
    configure(4, 10, 60, 58);
    startTracker("R2 init near max", 58);
    feed("R3 first step", 100, 100, 54);
    feed("R5 rise with V down", 90, 200, 58);
    feed("R8 clamp at max", 80, 300, 60);
    feed("R9 forced down at max", 70, 400, 56);
    stopTracker();
  endtask

  task automatic tInitClamp();
    configure(4, 10, 60, 3);
    startTracker("R2 init below min", 10);
    stopTracker();
    configure(4, 10, 60, 90);
    startTracker("R2 init above max", 60);
    stopTracker();
  endtask

  task automatic tPwmFull();
    configure(4, 70, 100, 80);
    startTracker("R2 init large", 80);
    for (int k = 0; k < 2 * PERIOD + 4; k++) @(negedge clk);
    countHigh("R11 duty beyond period", PERIOD);
    stopTracker();
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDecisionTable();
    tClampMin();
    tClampMax();
    tInitClamp();
    tPwmFull();
    finishRun();
  end

endmodule